// File: doc/BRIEF.md
# Restoring Shift-Subtract Divider

This block divides one unsigned W-bit number by another over several clock cycles. A one-cycle `start` pulse captures both operands. The block then runs a fixed sequence of trial subtractions and returns a W-bit quotient and a W-bit remainder, together with a one-cycle `done` pulse. The results stay on the output ports until the next division is accepted.

The datapath has three registers:
- a remainder register, 2W+1 bits wide, which is loaded with the dividend;
- a divisor register, 2W bits wide, which is loaded with the divisor in its upper half and shifts right by one bit on every step;
- a quotient register, which shifts left and takes in one new bit on every step.

On each step the block subtracts the divisor register from the remainder register and looks at the sign of the difference. A negative difference is undone, so the remainder returns to its previous value and a 0 enters the quotient. A non-negative difference is kept and a 1 enters the quotient. A division takes W+1 steps. When the divisor is zero, the block does not run the loop and returns a fixed result instead.

Top module: `restoring_divider`

## Requirements
- R1: After reset, `quotient` and `remainder` are all zeros and `done` is low.
- R2: For a non-zero divisor, `done` goes high when W+1 further rising edges have passed after the edge that accepts `start`. It reads high just after that last edge.
- R3: With a non-zero divisor, the results satisfy dividend = quotient × divisor + remainder and remainder < divisor. This is the same as quotient = floor(dividend / divisor) and remainder = dividend mod divisor.
- R4: When the divisor is zero, `done` reads high just after the accepting edge. The quotient is all ones and the remainder equals the dividend.
- R5: `done` is high for exactly one cycle per accepted division.
- R6: After `done`, `quotient` and `remainder` keep their values until another `start` is accepted, even if the operand inputs change.
- R7: A `start` pulse is accepted only while no division is in progress. A pulse that arrives during a division has no effect on the result of that division.
- R8: On each step whose trial difference is negative, the remainder register is left unchanged (restored) and a 0 enters the quotient. On a step whose difference is non-negative, a 1 enters the quotient.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse; operands are sampled on the edge that accepts it |
| dividend | input | W | Unsigned dividend |
| divisor | input | W | Unsigned divisor |
| quotient | output | W | Unsigned quotient |
| remainder | output | W | Unsigned remainder |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check the following on every cycle:
- the timing of `done`, measured against an independent countdown;
- the width of the `done` pulse;
- that the outputs stay stable while the block is idle;
- the fixed result for a zero divisor;
- the rule for restoring the remainder and choosing the quotient bit on each step;
- the division identity at completion, computed on operands that the checker latches itself.

The bench scenarios cover the rest. These are an exhaustive sweep of every operand pair at a small width, the values seen right after reset, results held while the inputs change, and a `start` pulse inserted in the middle of a division.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic {
    DIV_IDLE = 1'b0,
    DIV_RUN  = 1'b1
  } div_state_e;
endpackage

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic div_zero,
  output logic accept,
  output logic load_zero,
  output logic step_fire,
  output logic last_step,
  output logic busy,
  output logic done
);
  localparam int STEPS = W + 1;
  localparam int CW    = $clog2(STEPS + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(STEPS - 1);

  div_state_e      state_q;
  logic [CW-1:0]   step_cnt_q;

  assign busy      = (state_q == DIV_RUN);
  assign accept    = start && !busy;
  assign load_zero = accept && div_zero;
  assign step_fire = busy;
  assign last_step = step_fire && (step_cnt_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= DIV_IDLE;
      step_cnt_q <= '0;
      done       <= 1'b0;
    end else begin
      done <= load_zero || last_step;
      if (accept && !div_zero) begin
        state_q    <= DIV_RUN;
        step_cnt_q <= '0;
      end else if (last_step) begin
        state_q    <= DIV_IDLE;
        step_cnt_q <= '0;
      end else if (step_fire) begin
        step_cnt_q <= step_cnt_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/div_datapath.sv
module div_datapath #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         load_zero,
  input  logic         step_fire,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         restore_taken,
  output logic [2*W:0] rem_reg
);
  localparam int RW = 2 * W + 1;
  localparam int DW = 2 * W;
  localparam int QW = W + 1;

  logic [DW-1:0] dsr_q;
  logic [QW-1:0] quo_q;
  logic [RW-1:0] diff;
  logic          diff_neg;

  function automatic logic [RW-1:0] trial_sub(input logic [RW-1:0] r,
                                              input logic [DW-1:0] d);
    return r - {1'b0, d};
  endfunction

  function automatic logic [QW-1:0] shift_in(input logic [QW-1:0] q,
                                             input logic b);
    return {q[QW-2:0], b};
  endfunction

  assign diff          = trial_sub(rem_reg, dsr_q);
  assign diff_neg      = diff[RW-1];
  assign restore_taken = step_fire && diff_neg;
  assign quotient      = quo_q[W-1:0];
  assign remainder     = rem_reg[W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_reg <= '0;
      dsr_q   <= '0;
      quo_q   <= '0;
    end else if (load) begin
      rem_reg <= {{(RW-W){1'b0}}, dividend};
      dsr_q   <= {divisor, {W{1'b0}}};
      quo_q   <= load_zero ? {QW{1'b1}} : '0;
    end else if (step_fire) begin
      rem_reg <= diff_neg ? rem_reg : diff;
      quo_q   <= shift_in(quo_q, !diff_neg);
      dsr_q   <= dsr_q >> 1;
    end
  end
endmodule

// File: rtl/restoring_divider.sv
module restoring_divider #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         done
);
  logic         accept;
  logic         load_zero;
  logic         step_fire;
  logic         last_step;
  logic         busy;
  logic         restore_taken;
  logic [2*W:0] rem_reg;
  logic         div_zero;

  assign div_zero = (divisor == '0);

  div_ctrl #(.W(W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .div_zero  (div_zero),
    .accept    (accept),
    .load_zero (load_zero),
    .step_fire (step_fire),
    .last_step (last_step),
    .busy      (busy),
    .done      (done)
  );

  div_datapath #(.W(W)) u_dp (
    .clk           (clk),
    .rst_n         (rst_n),
    .load          (accept),
    .load_zero     (load_zero),
    .step_fire     (step_fire),
    .dividend      (dividend),
    .divisor       (divisor),
    .quotient      (quotient),
    .remainder     (remainder),
    .restore_taken (restore_taken),
    .rem_reg       (rem_reg)
  );
endmodule

// File: rtl/div_checker.sv
module div_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W-1:0] dividend,
  input logic [W-1:0] divisor,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder,
  input logic         done,
  input logic         busy,
  input logic         accept,
  input logic         step_fire,
  input logic         restore_taken,
  input logic [2*W:0] rem_reg
);
  localparam int CW = $clog2(W + 3);
  localparam logic [CW-1:0] WAIT_INIT = CW'(W + 1);

  logic [CW-1:0] wait_q;
  logic          fin_q;
  logic [W-1:0]  lat_a;
  logic [W-1:0]  lat_b;
  logic [2*W:0]  recon;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= '0;
      fin_q  <= 1'b0;
      lat_a  <= '0;
      lat_b  <= '0;
    end else begin
      fin_q <= (wait_q == CW'(1)) || (accept && divisor == '0);
      if (accept) begin
        lat_a  <= dividend;
        lat_b  <= divisor;
        wait_q <= (divisor == '0) ? '0 : WAIT_INIT;
      end else if (wait_q != '0) begin
        wait_q <= wait_q - CW'(1);
      end
    end
  end

  assign recon = (2*W+1)'(quotient) * (2*W+1)'(lat_b) + (2*W+1)'(remainder);

  assert_done_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done == fin_q);

  assert_identity_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && lat_b != '0) |-> (recon == (2*W+1)'(lat_a) && remainder < lat_b));

  assert_zero_div_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && divisor == '0) |=> (done && quotient == '1 && remainder == $past(dividend)));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !accept) |=> ($stable(quotient) && $stable(remainder)));

  assert_no_accept_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept);

  assert_restore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restore_taken |=> ($stable(rem_reg) && quotient[0] == 1'b0));

  assert_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && !restore_taken) |=> quotient[0] == 1'b1);
endmodule

bind restoring_divider div_checker #(.W(W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .dividend      (dividend),
  .divisor       (divisor),
  .quotient      (quotient),
  .remainder     (remainder),
  .done          (done),
  .busy          (busy),
  .accept        (accept),
  .step_fire     (step_fire),
  .restore_taken (restore_taken),
  .rem_reg       (rem_reg)
);

// File: tb/tb_restoring_divider.sv
`timescale 1ns/1ps
module tb_restoring_divider;
  localparam int W = 5;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic [W-1:0] quotient;
  logic [W-1:0] remainder;
  logic         done;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  restoring_divider #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .dividend(dividend), .divisor(divisor),
    .quotient(quotient), .remainder(remainder), .done(done)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_div(input int a, input int b, output int lat);
    @(negedge clk);
    start = 1'b1; dividend = W'(a); divisor = W'(b);
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1 quotient", int'(quotient), 0);
    check("R1 remainder", int'(remainder), 0);
    check("R1 done", int'(done), 0);
    rst_n = 1'b1;

    // R2 R3 R4: exhaustive sweep
    for (int a = 0; a <= MAXV; a++) begin
      for (int b = 0; b <= MAXV; b++) begin
        run_div(a, b, lat);
        if (b == 0) begin
          check("R4 latency", lat, 1);
          check("R4 quotient", int'(quotient), MAXV);
          check("R4 remainder", int'(remainder), a);
        end else begin
          check("R2 latency", lat, W + 2);
          check("R3 quotient", int'(quotient), a / b);
          check("R3 remainder", int'(remainder), a % b);
          check("R3 identity", int'(quotient) * b + int'(remainder), a);
        end
        // R5: one-cycle pulse
        @(negedge clk);
        check("R5 done width", int'(done), 0);
      end
    end

    // R6: hold while inputs change
    run_div(29, 6, lat);
    dividend = W'(3); divisor = W'(7);
    repeat (4) @(negedge clk);
    check("R6 quotient hold", int'(quotient), 4);
    check("R6 remainder hold", int'(remainder), 5);

    // R7: start during a division is ignored
    @(negedge clk);
    start = 1'b1; dividend = W'(31); divisor = W'(4);
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    start = 1'b1; dividend = W'(9); divisor = W'(0);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    check("R7 quotient", int'(quotient), 7);
    check("R7 remainder", int'(remainder), 3);

    // R8: all steps restore (dividend < divisor) and no restore except one
    run_div(2, 30, lat);
    check("R8 all-restore quotient", int'(quotient), 0);
    check("R8 all-restore remainder", int'(remainder), 2);
    run_div(31, 1, lat);
    check("R8 no-restore quotient", int'(quotient), 31);
    check("R8 no-restore remainder", int'(remainder), 0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule